// File: doc/BRIEF.md
# Context-Tagged Address Translation Cache with Table Walk

This block turns 32-bit virtual byte addresses into 24-bit physical byte addresses using 1 KB pages. It keeps four recently used translations in a fully associative array. Every entry is tagged with both the virtual page number and the number of the address space that loaded it. A request whose context and page number match a valid entry completes one cycle after it is accepted, with no memory traffic.

On a miss, the block reads one 16-bit page-table entry through a valid/ready memory port. The entry index is the table base register plus the virtual page number. A resident entry is installed in the array, and the request then completes with the physical address. A non-resident entry completes the request with a fault flag and is never cached.

Software changes address spaces by writing only the context register and the table base register. Translations that belong to other contexts stay in the array and remain usable when the system switches back. A flush input clears the whole array in one cycle.

Top module: `ctx_tlb_top`

## Requirements
- R1: The virtual page number is VA[31:10], and VA[9:0] passes unchanged to PA[9:0]. PA[23:10] carries the 14-bit physical page number.
- R2: A request accepted while the current context and VA[31:10] match a valid entry raises tr_done with tr_paddr one cycle after acceptance, and issues no page-table request.
- R3: On a miss the block makes exactly one page-table request at index (table base + virtual page number) mod 2^22. The request holds valid and the same address until ready is seen, and no request is raised while the block is idle.
- R4: A page-table entry has bit 15 = resident, bit 14 = dirty and bits 13:0 = physical page number. For a resident entry the block installs it and raises tr_done, with the translated address and tr_fault low, one cycle after the response beat.
- R5: A non-resident entry raises tr_done and tr_fault together and is not cached, so the same page walks again on the next request. tr_fault is never high without tr_done.
- R6: The context and table base registers are captured at acceptance. Writing them flushes nothing, and the same page number under two contexts occupies two separate entries.
- R7: flush invalidates all entries in one cycle and returns the replacement pointer to entry 0.
- R8: An install takes the lowest-numbered invalid entry. When every entry is valid, it takes the entry under a round-robin pointer, which starts at 0 and advances by one after each such replacement.
- R9: During and after reset, all entries are invalid, tr_ready is 1, tr_done is 0 and pt_req_valid is 0.
- R10: At most one entry matches any context/page pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all translations |
| ctx_we | input | 1 | Write enable for the context register |
| ctx_wdata | input | CTX_W | New context number |
| ptbr_we | input | 1 | Write enable for the table base register |
| ptbr_wdata | input | 22 | New table base (entry index) |
| tr_valid | input | 1 | Translation request |
| tr_vaddr | input | 32 | Virtual byte address |
| tr_ready | output | 1 | Block idle, request accepted when tr_valid is high |
| tr_done | output | 1 | One-cycle completion pulse |
| tr_fault | output | 1 | Page fault, valid with tr_done |
| tr_paddr | output | 24 | Physical byte address, valid with tr_done |
| pt_req_valid | output | 1 | Page-table read request |
| pt_req_ready | input | 1 | Memory accepts the request |
| pt_req_addr | output | 22 | Page-table entry index |
| pt_rsp_valid | input | 1 | Response beat |
| pt_rsp_data | input | 16 | Page-table entry |

## Verification
The bench targets context aliasing: the same page under two contexts with different frames. A design that left the context out of the tag would return the wrong frame after a switch. A design that flushed on a register write would walk again where a hit is expected. It sends a non-resident page twice; a design that cached faults would skip the second walk. It fills all four entries and then forces a sequence of evictions, so an incorrect replacement pointer turns expected hits into extra walks. The top page number with a zero base probes truncation of the 22-bit index, and a stalled ready checks that the request is held.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W          = 32;
  localparam int PA_W          = 24;
  localparam int PG_W          = 10;
  localparam int VPN_W         = VA_W - PG_W;
  localparam int PPN_W         = PA_W - PG_W;
  localparam int PTE_W         = 16;
  localparam int PTE_RES_BIT   = 15;
  localparam int PTE_DIRTY_BIT = 14;

  typedef enum logic [1:0] {WK_IDLE, WK_REQ, WK_WAIT} wk_state_t;

  function automatic logic [VPN_W-1:0] va_vpn(input logic [VA_W-1:0] va);
    return va[VA_W-1:PG_W];
  endfunction

  function automatic logic [PG_W-1:0] va_off(input logic [VA_W-1:0] va);
    return va[PG_W-1:0];
  endfunction

  function automatic logic [PA_W-1:0] form_pa(input logic [PPN_W-1:0] ppn,
                                               input logic [PG_W-1:0]  off);
    return {ppn, off};
  endfunction

  function automatic logic [VPN_W-1:0] walk_index(input logic [VPN_W-1:0] base,
                                                  input logic [VPN_W-1:0] vpn);
    return base + vpn;
  endfunction
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int CTX_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [CTX_W-1:0] lk_ctx,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  input  logic             fill_en,
  input  logic [CTX_W-1:0] fill_ctx,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] ent_valid;
  logic [CTX_W-1:0]   ent_ctx [ENTRIES];
  logic [VPN_W-1:0]   ent_vpn [ENTRIES];
  logic [PPN_W-1:0]   ent_ppn [ENTRIES];
  logic [ENTRIES-1:0] match;
  logic [IDX_W-1:0]   rr_ptr;
  logic [IDX_W-1:0]   victim;
  logic               all_valid;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = ent_valid[g] && (ent_ctx[g] == lk_ctx) && (ent_vpn[g] == lk_vpn);
  end

  assign lk_hit    = |match;
  assign all_valid = &ent_valid;

  always_comb begin
    lk_ppn = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match[i]) lk_ppn = lk_ppn | ent_ppn[i];
  end

  always_comb begin
    victim = rr_ptr;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!ent_valid[i]) victim = IDX_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_valid <= '0;
      rr_ptr    <= '0;
    end else if (flush) begin
      ent_valid <= '0;
      rr_ptr    <= '0;
    end else if (fill_en) begin
      ent_valid[victim] <= 1'b1;
      ent_ctx[victim]   <= fill_ctx;
      ent_vpn[victim]   <= fill_vpn;
      ent_ppn[victim]   <= fill_ppn;
      if (all_valid)
        rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
    end
  end

  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match)); // R10

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (ent_valid == '0) && (rr_ptr == '0)); // R7

  AST_FILL_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !flush && !all_valid) |=>
      ($countones(ent_valid) == $countones($past(ent_valid)) + 1)); // R8
endmodule

// File: rtl/tlb_walker.sv
module tlb_walker
  import tlb_pkg::*;
#(
  parameter int CTX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tr_valid,
  input  logic [VA_W-1:0]  tr_vaddr,
  output logic             tr_ready,
  output logic             tr_done,
  output logic             tr_fault,
  output logic [PA_W-1:0]  tr_paddr,
  input  logic [CTX_W-1:0] cur_ctx,
  input  logic [VPN_W-1:0] cur_ptbr,
  output logic [CTX_W-1:0] lk_ctx,
  output logic [VPN_W-1:0] lk_vpn,
  input  logic             lk_hit,
  input  logic [PPN_W-1:0] lk_ppn,
  output logic             fill_en,
  output logic [CTX_W-1:0] fill_ctx,
  output logic [VPN_W-1:0] fill_vpn,
  output logic [PPN_W-1:0] fill_ppn,
  output logic             pt_req_valid,
  input  logic             pt_req_ready,
  output logic [VPN_W-1:0] pt_req_addr,
  input  logic             pt_rsp_valid,
  input  logic [PTE_W-1:0] pt_rsp_data
);
  wk_state_t        st;
  logic [CTX_W-1:0] held_ctx;
  logic [VPN_W-1:0] held_vpn;
  logic [PG_W-1:0]  held_off;
  logic [VPN_W-1:0] held_idx;

  logic accept, walk_start, walk_end, rsp_resident, dirty_unused;

  assign tr_ready     = (st == WK_IDLE);
  assign accept       = tr_valid && tr_ready;
  assign walk_start   = accept && !lk_hit;
  assign walk_end     = (st == WK_WAIT) && pt_rsp_valid;
  assign rsp_resident = pt_rsp_data[PTE_RES_BIT];
  assign dirty_unused = pt_rsp_data[PTE_DIRTY_BIT];

  assign lk_ctx       = cur_ctx;
  assign lk_vpn       = va_vpn(tr_vaddr);
  assign fill_en      = walk_end && rsp_resident;
  assign fill_ctx     = held_ctx;
  assign fill_vpn     = held_vpn;
  assign fill_ppn     = pt_rsp_data[PPN_W-1:0];
  assign pt_req_valid = (st == WK_REQ);
  assign pt_req_addr  = held_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= WK_IDLE;
      tr_done  <= 1'b0;
      tr_fault <= 1'b0;
      tr_paddr <= '0;
      held_ctx <= '0;
      held_vpn <= '0;
      held_off <= '0;
      held_idx <= '0;
    end else begin
      tr_done  <= 1'b0;
      tr_fault <= 1'b0;
      unique case (st)
        WK_IDLE: begin
          if (accept && lk_hit) begin
            tr_done  <= 1'b1;
            tr_paddr <= form_pa(lk_ppn, va_off(tr_vaddr));
          end else if (walk_start) begin
            held_ctx <= cur_ctx;
            held_vpn <= va_vpn(tr_vaddr);
            held_off <= va_off(tr_vaddr);
            held_idx <= walk_index(cur_ptbr, va_vpn(tr_vaddr));
            st       <= WK_REQ;
          end
        end
        WK_REQ: if (pt_req_ready) st <= WK_WAIT;
        WK_WAIT: begin
          if (pt_rsp_valid) begin
            tr_done  <= 1'b1;
            tr_fault <= !rsp_resident;
            tr_paddr <= rsp_resident ? form_pa(pt_rsp_data[PPN_W-1:0], held_off) : '0;
            st       <= WK_IDLE;
          end
        end
        default: st <= WK_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pt_req_valid && !pt_req_ready) |=> pt_req_valid && $stable(pt_req_addr)); // R3

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    tr_ready |-> !pt_req_valid); // R3

  AST_HIT_NO_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && lk_hit) |=> tr_done && !pt_req_valid); // R2

  AST_DONE_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    walk_end |=> tr_done && (tr_fault == !$past(rsp_resident))); // R4

  AST_FAULT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    tr_fault |-> tr_done); // R5
endmodule

// File: rtl/ctx_tlb_top.sv
module ctx_tlb_top
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int CTX_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             ctx_we,
  input  logic [CTX_W-1:0] ctx_wdata,
  input  logic             ptbr_we,
  input  logic [21:0]      ptbr_wdata,
  input  logic             tr_valid,
  input  logic [31:0]      tr_vaddr,
  output logic             tr_ready,
  output logic             tr_done,
  output logic             tr_fault,
  output logic [23:0]      tr_paddr,
  output logic             pt_req_valid,
  input  logic             pt_req_ready,
  output logic [21:0]      pt_req_addr,
  input  logic             pt_rsp_valid,
  input  logic [15:0]      pt_rsp_data
);
  logic [CTX_W-1:0] ctx_q;
  logic [VPN_W-1:0] ptbr_q;
  logic [CTX_W-1:0] lk_ctx, fill_ctx;
  logic [VPN_W-1:0] lk_vpn, fill_vpn;
  logic [PPN_W-1:0] lk_ppn, fill_ppn;
  logic             lk_hit, fill_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctx_q  <= '0;
      ptbr_q <= '0;
    end else begin
      if (ctx_we)  ctx_q  <= ctx_wdata;
      if (ptbr_we) ptbr_q <= ptbr_wdata;
    end
  end

  tlb_cam #(.ENTRIES(ENTRIES), .CTX_W(CTX_W)) cam_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_ctx(lk_ctx), .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_ppn(lk_ppn),
    .fill_en(fill_en), .fill_ctx(fill_ctx), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn)
  );

  tlb_walker #(.CTX_W(CTX_W)) walk_i (
    .clk(clk), .rst_n(rst_n),
    .tr_valid(tr_valid), .tr_vaddr(tr_vaddr), .tr_ready(tr_ready),
    .tr_done(tr_done), .tr_fault(tr_fault), .tr_paddr(tr_paddr),
    .cur_ctx(ctx_q), .cur_ptbr(ptbr_q),
    .lk_ctx(lk_ctx), .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_ppn(lk_ppn),
    .fill_en(fill_en), .fill_ctx(fill_ctx), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .pt_req_valid(pt_req_valid), .pt_req_ready(pt_req_ready), .pt_req_addr(pt_req_addr),
    .pt_rsp_valid(pt_rsp_valid), .pt_rsp_data(pt_rsp_data)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> tr_ready && !tr_done && !pt_req_valid); // R9
endmodule

// File: tb/ctx_tlb_top_tb.sv
`timescale 1ns/1ps
module ctx_tlb_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        ctx_we = 1'b0;
  logic [3:0]  ctx_wdata = '0;
  logic        ptbr_we = 1'b0;
  logic [21:0] ptbr_wdata = '0;
  logic        tr_valid = 1'b0;
  logic [31:0] tr_vaddr = '0;
  logic        tr_ready, tr_done, tr_fault;
  logic [23:0] tr_paddr;
  logic        pt_req_valid;
  logic        mem_ready = 1'b0;
  logic [21:0] pt_req_addr;
  logic        rsp_v = 1'b0;
  logic [15:0] rsp_d = '0;

  logic [15:0] ptmem [64];
  int          walks = 0;
  logic [21:0] last_addr = '0;
  int          nchk = 0;
  int          nfail = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  ctx_tlb_top dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .ctx_we(ctx_we), .ctx_wdata(ctx_wdata), .ptbr_we(ptbr_we), .ptbr_wdata(ptbr_wdata),
    .tr_valid(tr_valid), .tr_vaddr(tr_vaddr), .tr_ready(tr_ready),
    .tr_done(tr_done), .tr_fault(tr_fault), .tr_paddr(tr_paddr),
    .pt_req_valid(pt_req_valid), .pt_req_ready(mem_ready), .pt_req_addr(pt_req_addr),
    .pt_rsp_valid(rsp_v), .pt_rsp_data(rsp_d)
  );

  // memory model: ready one cycle late (stall), response one cycle after handshake
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ready <= 1'b0;
      rsp_v     <= 1'b0;
    end else begin
      mem_ready <= pt_req_valid && !mem_ready;
      rsp_v     <= 1'b0;
      if (pt_req_valid && mem_ready) begin
        walks     <= walks + 1;
        last_addr <= pt_req_addr;
        rsp_v     <= 1'b1;
        rsp_d     <= ptmem[pt_req_addr[5:0]];
      end
    end
  end

  function automatic logic [15:0] pte(input bit r, input bit d, input logic [13:0] ppn);
    return {r, d, ppn};
  endfunction

  task automatic chk(input string rq, input string what, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  task automatic set_ctx(input logic [3:0] c);
    @(negedge clk);
    ctx_we = 1'b1; ctx_wdata = c;
    ptbr_we = 1'b1; ptbr_wdata = 22'(c) * 22'd32;
    @(negedge clk);
    ctx_we = 1'b0; ptbr_we = 1'b0;
  endtask

  task automatic xlat(input logic [3:0] c, input logic [31:0] va, input bit ef,
                      input logic [23:0] epa, input bit ew, input logic [21:0] ea,
                      input string rq);
    int w0;
    int n;
    set_ctx(c);
    w0 = walks;
    n = 0;
    tr_valid = 1'b1; tr_vaddr = va;
    @(negedge clk);
    tr_valid = 1'b0;
    while (!tr_done && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk(rq, "done", tr_done, 1);
    chk(rq, "fault", tr_fault, ef);
    if (!ef) chk(rq, "paddr", tr_paddr, epa);
    chk(rq, "walks", walks - w0, ew ? 1 : 0);
    if (ew) chk(rq, "table index", last_addr, ea);
  endtask

  typedef struct packed {
    logic [3:0]  ctx;
    logic [31:0] va;
    logic        flt;
    logic [23:0] pa;
    logic        walk;
    logic [21:0] addr;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{4'd0, 32'h0000_1804, 1'b0, 24'h000804, 1'b1, 22'h6},      // R1 R3 R4 miss then fill
    '{4'd0, 32'h0000_1808, 1'b0, 24'h000808, 1'b0, 22'h0},      // R2 hit
    '{4'd0, 32'h0000_1080, 1'b0, 24'h001480, 1'b1, 22'h4},      // R4
    '{4'd0, 32'h0000_00FC, 1'b1, 24'h000000, 1'b1, 22'h0},      // R5 fault
    '{4'd0, 32'h0000_00FC, 1'b1, 24'h000000, 1'b1, 22'h0},      // R5 not cached
    '{4'd1, 32'h0000_1804, 1'b0, 24'hFFFC04, 1'b1, 22'h26},     // R6 other context
    '{4'd0, 32'h0000_1BFF, 1'b0, 24'h000BFF, 1'b0, 22'h0},      // R6 no flush on switch
    '{4'd1, 32'h0000_1800, 1'b0, 24'hFFFC00, 1'b0, 22'h0},      // R6
    '{4'd0, 32'hFFFF_FFFF, 1'b0, 24'h02AFFF, 1'b1, 22'h3FFFFF}, // R1 R3 top page
    '{4'd0, 32'h0000_0C00, 1'b1, 24'h000000, 1'b1, 22'h3}       // R4 R5 resident bit only
  };

  initial begin
    for (int i = 0; i < 64; i++) ptmem[i] = 16'h0000;
    ptmem[1]  = pte(1'b1, 1'b1, 14'd9);
    ptmem[2]  = pte(1'b1, 1'b0, 14'd0);
    ptmem[3]  = pte(1'b0, 1'b1, 14'd5);
    ptmem[4]  = pte(1'b1, 1'b0, 14'd5);
    ptmem[6]  = pte(1'b1, 1'b1, 14'd2);
    ptmem[7]  = pte(1'b1, 1'b0, 14'd4);
    ptmem[38] = pte(1'b1, 1'b0, 14'h3FFF);
    ptmem[63] = pte(1'b1, 1'b0, 14'h0AB);

    repeat (3) @(negedge clk);
    chk("R9", "ready in reset", tr_ready, 1);
    chk("R9", "done in reset", tr_done, 0);
    chk("R9", "req in reset", pt_req_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "ready after reset", tr_ready, 1);

    for (int k = 0; k < NV; k++)
      xlat(VEC[k].ctx, VEC[k].va, VEC[k].flt, VEC[k].pa, VEC[k].walk, VEC[k].addr, "R2 R4 R6");

    // array full (ctx0 vpn6, ctx0 vpn4, ctx1 vpn6, ctx0 top page); pointer at 0
    xlat(4'd0, 32'h0000_1C00, 1'b0, 24'h001000, 1'b1, 22'h7, "R8 evict entry 0");
    xlat(4'd0, 32'h0000_1804, 1'b0, 24'h000804, 1'b1, 22'h6, "R8 entry 0 gone");
    xlat(4'd0, 32'h0000_1080, 1'b0, 24'h001480, 1'b1, 22'h4, "R8 entry 1 gone");
    xlat(4'd1, 32'h0000_1804, 1'b0, 24'hFFFC04, 1'b1, 22'h26, "R8 entry 2 gone");
    xlat(4'd0, 32'h0000_1C04, 1'b0, 24'h001004, 1'b0, 22'h0, "R8 survivor hits");

    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    xlat(4'd0, 32'h0000_1C00, 1'b0, 24'h001000, 1'b1, 22'h7, "R7 walk after flush");
    xlat(4'd0, 32'h0000_0400, 1'b0, 24'h002400, 1'b1, 22'h1, "R8 fill invalid");
    xlat(4'd0, 32'h0000_1C10, 1'b0, 24'h001010, 1'b0, 22'h0, "R8 first fill kept");

    finished = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule